// File: doc/BRIEF.md
# Multichannel Acquisition Stream Buffer

This block sits between a multichannel sampling front end and a consumer that reads data at its own pace. A programmable period counter asks the front end for one scan. The front end answers with one word per channel, always in the same channel order. The words go first into a local FIFO on the acquisition side. A transfer engine then moves them into a second FIFO on the consumer side, which the consumer drains through a ready/valid read port.

A transfer begins when the local FIFO is full or when a periodic flush timer runs out, whichever comes first. Each word moves only while the consumer FIFO has room. Otherwise the engine waits, and if it waits too long a timeout flag is raised. Words are never lost one at a time, because a lost word would shift every later channel. Instead, a scan that cannot fit in full is dropped as a whole and counted, so the channel order at the consumer stays intact.

Acquisition starts and stops on command. A stop lets any scan in progress complete, flushes everything left in the local FIFO, and then returns the block to idle. From idle it can be started again.

Top module: `acq_stream_buf`

## Requirements
- R1: After a start, the first scan request appears in the first cycle in the running state. Later requests follow every `scan_period` cycles. A request that falls due while the previous scan is still arriving waits until that scan's last word has been taken. Each request lasts exactly one cycle.
- R2: Each scan takes the next NCH words presented with `smp_valid`. The consumer receives them in arrival order. Words presented while no scan is open are ignored.
- R3: At a scan request, if the local FIFO has fewer than NCH free entries, all NCH words of that scan are discarded. In that case `ovf_flag` is set and `drop_count` increases by one. Otherwise `drop_count` does not change.
- R4: `ovf_flag` and `timeout_flag` stay set until a `status_clear` pulse. If a new setting event occurs in the same cycle as the clear, the setting event wins.
- R5: While the block is active and the engine is idle, a drain begins when the local FIFO is full, when the flush timer reaches `flush_interval`, or during the stop flush. A drain begins only if the local FIFO holds data. The timer restarts after each trigger and after each drain.
- R6: A drain moves one word per cycle, and only in cycles where the consumer FIFO is not full. It ends when the local FIFO is empty.
- R7: If a drain stalls on a full consumer FIFO for more than `drain_timeout` consecutive cycles, `timeout_flag` is set.
- R8: A stop lets the open scan complete and issues no new request. It then flushes the local FIFO. `busy` falls only once the local FIFO is empty and no drain is in progress. A start while running is ignored.
- R9: After reset, the outputs are `busy`, `rd_valid`, `scan_req`, `ovf_flag` and `timeout_flag` all low, and `drop_count` zero.
- R10: `rd_valid` is high while the consumer FIFO holds a word. `rd_data` shows the oldest word, which is removed in a cycle with `rd_valid` and `rd_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, acted on only when idle |
| stop | input | 1 | Stop pulse |
| status_clear | input | 1 | Clears the overflow and timeout flags |
| scan_period | input | PW | Cycles between scan requests |
| flush_interval | input | FW | Flush timer limit in cycles |
| drain_timeout | input | TW | Stall cycles allowed before timeout |
| smp_valid | input | 1 | Sample word valid |
| smp_data | input | DW | Sample word |
| scan_req | output | 1 | One-cycle request for a new scan |
| rd_ready | input | 1 | Consumer accepts the shown word |
| rd_valid | output | 1 | Consumer FIFO holds a word |
| rd_data | output | DW | Oldest word in the consumer FIFO |
| busy | output | 1 | Block not idle |
| ovf_flag | output | 1 | Sticky: a scan was dropped |
| timeout_flag | output | 1 | Sticky: a drain stalled too long |
| drop_count | output | DCW | Number of dropped scans |

## Verification
The embedded properties check, on every cycle, the local behaviours that the logic itself guarantees:
- neither FIFO is ever pushed while full;
- a drop always raises the overflow flag, and the count steps only on a drop;
- both flags hold until cleared;
- a drain starts only with data present;
- a timeout rises only out of a stall;
- the stop path waits for the open scan and reaches idle only with an empty local FIFO.

End-to-end properties can only be shown by the bench's scenarios, which compare the design against a queue model on every cycle. These are that channel order survives at the consumer under heavy overflow, that the period holds exactly, and that every kept word arrives after a stop.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_RUN  = 2'd1,
    ACQ_FIN  = 2'd2
  } acq_state_t;

  // a whole scan fits only if every word of it has a free entry
  function automatic logic scan_fits(input int unsigned level,
                                     input int unsigned depth,
                                     input int unsigned nch);
    return (level <= depth) && ((depth - level) >= nch);
  endfunction

  // value loaded into the period counter after a request
  function automatic int unsigned period_reload(input int unsigned period);
    return (period == 0) ? 0 : period - 1;
  endfunction

  function automatic logic limit_reached(input int unsigned count,
                                         input int unsigned limit);
    return count >= limit;
  endfunction

endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 48,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // R3 R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6 R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/acq_scan_ctrl.sv
module acq_scan_ctrl
  import acq_pkg::*;
#(
  parameter  int NCH    = 12,
  parameter  int DW     = 16,
  parameter  int PW     = 16,
  parameter  int DCW    = 16,
  parameter  int LDEPTH = 48,
  localparam int LLW    = $clog2(LDEPTH + 1),
  localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic           status_clear,
  input  logic [PW-1:0]  scan_period,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  input  logic [LLW-1:0] local_level,
  input  logic           xfer_active,
  output logic           scan_req,
  output logic           lw_en,
  output logic [DW-1:0]  lw_data,
  output acq_state_t     state,
  output logic           ovf_flag,
  output logic [DCW-1:0] drop_count
);

  acq_state_t    st;
  logic [PW-1:0] cnt;
  logic [IW-1:0] widx;
  logic          in_scan, keep, stop_pend;
  logic          fits, drop_evt, last_word, stop_now, local_empty;

  assign local_empty = (local_level == '0);
  assign stop_now    = stop || stop_pend;
  assign scan_req    = (st == ACQ_RUN) && !in_scan && !stop_now && (cnt == '0);
  assign fits        = scan_fits(32'(local_level), LDEPTH, NCH);
  assign drop_evt    = scan_req && !fits;
  assign last_word   = in_scan && smp_valid && (widx == IW'(NCH - 1));
  assign lw_en       = in_scan && keep && smp_valid;
  assign lw_data     = smp_data;
  assign state       = st;

  // run control and scan period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ACQ_IDLE;
      cnt       <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (st)
        ACQ_IDLE: begin
          stop_pend <= 1'b0;
          if (start) begin
            st  <= ACQ_RUN;
            cnt <= '0;
          end
        end
        ACQ_RUN: begin
          if (stop_now && !in_scan) begin
            st        <= ACQ_FIN;
            stop_pend <= 1'b0;
          end else if (stop) begin
            stop_pend <= 1'b1;
          end
          if (scan_req)        cnt <= PW'(period_reload(32'(scan_period)));
          else if (cnt != '0)  cnt <= cnt - 1'b1;
        end
        ACQ_FIN: begin
          if (local_empty && !xfer_active) st <= ACQ_IDLE;
        end
        default: st <= ACQ_IDLE;
      endcase
    end
  end

  // scan word tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_scan <= 1'b0;
      keep    <= 1'b0;
      widx    <= '0;
    end else if (scan_req) begin
      in_scan <= 1'b1;
      keep    <= fits;
      widx    <= '0;
    end else if (in_scan && smp_valid) begin
      widx <= widx + 1'b1;
      if (last_word) in_scan <= 1'b0;
    end
  end

  // overflow status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      drop_count <= '0;
    end else begin
      if (drop_evt)          ovf_flag <= 1'b1;
      else if (status_clear) ovf_flag <= 1'b0;
      if (drop_evt) drop_count <= drop_count + 1'b1;
    end
  end

  // R3
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);

  // R3
  drop_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(drop_count));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !status_clear) |=> ovf_flag);

  // R1
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |=> !scan_req);

  // R8
  fin_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ACQ_FIN) && ($past(st) == ACQ_RUN)) |-> !$past(in_scan));

endmodule

// File: rtl/acq_xfer.sv
module acq_xfer #(
  parameter  int FW     = 16,
  parameter  int TW     = 16,
  parameter  int LDEPTH = 48,
  localparam int LLW    = $clog2(LDEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           force_flush,
  input  logic [LLW-1:0] local_level,
  input  logic           cons_full,
  input  logic [FW-1:0]  flush_interval,
  input  logic [TW-1:0]  drain_timeout,
  input  logic           status_clear,
  output logic           move,
  output logic           xfer_active,
  output logic           timeout_flag
);

  import acq_pkg::*;

  logic [FW-1:0] timer;
  logic [TW-1:0] waitc;
  logic          moving, local_full, local_empty;
  logic          timer_expired, wait_expired, trigger, stall;

  assign local_full    = (local_level == LLW'(LDEPTH));
  assign local_empty   = (local_level == '0);
  assign timer_expired = limit_reached(32'(timer), 32'(flush_interval));
  assign wait_expired  = limit_reached(32'(waitc), 32'(drain_timeout));
  assign trigger       = !moving && active && (local_full || timer_expired || force_flush);
  assign stall         = moving && !local_empty && cons_full;
  assign move          = moving && !local_empty && !cons_full;
  assign xfer_active   = moving;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moving <= 1'b0;
      timer  <= '0;
      waitc  <= '0;
    end else if (!moving) begin
      waitc <= '0;
      if (!active) begin
        timer <= '0;
      end else if (trigger) begin
        timer <= '0;
        if (!local_empty) moving <= 1'b1;
      end else begin
        timer <= timer + 1'b1;
      end
    end else begin
      if (local_empty) begin
        moving <= 1'b0;
        timer  <= '0;
        waitc  <= '0;
      end else if (cons_full) begin
        if (!wait_expired) waitc <= waitc + 1'b1;
      end else begin
        waitc <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     timeout_flag <= 1'b0;
    else if (stall && wait_expired) timeout_flag <= 1'b1;
    else if (status_clear)          timeout_flag <= 1'b0;
  end

  // R5
  drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> ($past(active) && !$past(local_empty)));

  // R7
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(stall));

  // R4
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !status_clear) |=> timeout_flag);

endmodule

// File: rtl/acq_stream_buf.sv
module acq_stream_buf
  import acq_pkg::*;
#(
  parameter int NCH    = 12,
  parameter int DW     = 16,
  parameter int LDEPTH = 48,
  parameter int CDEPTH = 32,
  parameter int PW     = 16,
  parameter int FW     = 16,
  parameter int TW     = 16,
  parameter int DCW    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic           status_clear,
  input  logic [PW-1:0]  scan_period,
  input  logic [FW-1:0]  flush_interval,
  input  logic [TW-1:0]  drain_timeout,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  output logic           scan_req,
  input  logic           rd_ready,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           busy,
  output logic           ovf_flag,
  output logic           timeout_flag,
  output logic [DCW-1:0] drop_count
);

  localparam int LLW = $clog2(LDEPTH + 1);
  localparam int CLW = $clog2(CDEPTH + 1);

  acq_state_t     acq_st;
  logic [LLW-1:0] l_level;
  logic [CLW-1:0] c_level;
  logic [DW-1:0]  lw_data, l_rdata;
  logic           lw_en, move, xfer_active, c_full, c_pop;

  assign c_full   = (c_level == CLW'(CDEPTH));
  assign rd_valid = (c_level != '0);
  assign c_pop    = rd_valid && rd_ready;
  assign busy     = (acq_st != ACQ_IDLE);

  acq_scan_ctrl #(
    .NCH(NCH), .DW(DW), .PW(PW), .DCW(DCW), .LDEPTH(LDEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .status_clear(status_clear), .scan_period(scan_period),
    .smp_valid(smp_valid), .smp_data(smp_data), .local_level(l_level),
    .xfer_active(xfer_active), .scan_req(scan_req), .lw_en(lw_en),
    .lw_data(lw_data), .state(acq_st), .ovf_flag(ovf_flag),
    .drop_count(drop_count)
  );

  acq_fifo #(.DW(DW), .DEPTH(LDEPTH)) u_local (
    .clk(clk), .rst_n(rst_n), .push(lw_en), .wdata(lw_data),
    .pop(move), .rdata(l_rdata), .level(l_level)
  );

  acq_xfer #(.FW(FW), .TW(TW), .LDEPTH(LDEPTH)) u_xfer (
    .clk(clk), .rst_n(rst_n), .active(busy),
    .force_flush(acq_st == ACQ_FIN), .local_level(l_level),
    .cons_full(c_full), .flush_interval(flush_interval),
    .drain_timeout(drain_timeout), .status_clear(status_clear),
    .move(move), .xfer_active(xfer_active), .timeout_flag(timeout_flag)
  );

  acq_fifo #(.DW(DW), .DEPTH(CDEPTH)) u_cons (
    .clk(clk), .rst_n(rst_n), .push(move), .wdata(l_rdata),
    .pop(c_pop), .rdata(rd_data), .level(c_level)
  );

  // R8
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (l_level == '0));

  // R6
  move_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> (c_level != '0));

endmodule

// File: tb/sim_acq_stream_buf.sv
module sim_acq_stream_buf;
  localparam int NCH = 12, DW = 16, LDEPTH = 48, CDEPTH = 32;
  localparam int PW = 16, FW = 16, TW = 16, DCW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, stop = 0, status_clear = 0, smp_valid = 0, rd_ready = 0;
  logic [PW-1:0] scan_period = 40;
  logic [FW-1:0] flush_interval = 30;
  logic [TW-1:0] drain_timeout = 20;
  logic [DW-1:0] smp_data = '0;
  logic scan_req, rd_valid, busy, ovf_flag, timeout_flag;
  logic [DW-1:0] rd_data;
  logic [DCW-1:0] drop_count;

  acq_stream_buf #(.NCH(NCH), .DW(DW), .LDEPTH(LDEPTH), .CDEPTH(CDEPTH),
                   .PW(PW), .FW(FW), .TW(TW), .DCW(DCW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .status_clear(status_clear), .scan_period(scan_period),
    .flush_interval(flush_interval), .drain_timeout(drain_timeout),
    .smp_valid(smp_valid), .smp_data(smp_data), .scan_req(scan_req),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .ovf_flag(ovf_flag), .timeout_flag(timeout_flag),
    .drop_count(drop_count));

  int checks = 0, fails = 0, cyc = 0;
  int reqs = 0, words_read = 0, exp_ch = 0, last_req = -1;
  bit gap_chk = 0, gap_mode = 0, noise = 0, ready_mode = 0, ready_hold = 1;

  // behavioural reference: 0 idle, 1 running, 2 finishing
  int m_st, m_cnt, m_in, m_keep, m_idx, m_sp, m_ovf, m_drops;
  int m_mov, m_timer, m_wait, m_tmo;
  logic [DW-1:0] lq[$], cq[$];
  int src_pend = 0, src_ch = 0, src_scan = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic bit pred_req();
    return (m_st == 1) && !m_in && !m_sp && !stop && (m_cnt == 0);
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_in = 0; m_keep = 0; m_idx = 0; m_sp = 0;
    m_ovf = 0; m_drops = 0; m_mov = 0; m_timer = 0; m_wait = 0; m_tmo = 0;
    lq.delete(); cq.delete();
    src_pend = 0; src_ch = 0;
  endtask

  task automatic model_step();
    int lvl, csz, n_st, n_cnt, n_sp;
    bit sreq, fits, wr, lempty, cfull, lfull, mv, stall, active, force_f;
    lvl = lq.size(); csz = cq.size();
    sreq = pred_req();
    fits = (LDEPTH - lvl) >= NCH;
    wr = m_in && m_keep && smp_valid;
    lempty = (lvl == 0); cfull = (csz == CDEPTH); lfull = (lvl == LDEPTH);
    mv = m_mov && !lempty && !cfull;
    stall = m_mov && !lempty && cfull;
    active = (m_st != 0); force_f = (m_st == 2);
    if (csz > 0 && rd_ready) void'(cq.pop_front());
    if (mv) cq.push_back(lq.pop_front());
    if (wr) lq.push_back(smp_data);
    n_st = m_st; n_cnt = m_cnt; n_sp = m_sp;
    case (m_st)
      0: begin n_sp = 0; if (start) begin n_st = 1; n_cnt = 0; end end
      1: begin
        if ((stop || m_sp) && !m_in) begin n_st = 2; n_sp = 0; end
        else if (stop) n_sp = 1;
        if (sreq) n_cnt = (scan_period == 0) ? 0 : int'(scan_period) - 1;
        else if (m_cnt != 0) n_cnt = m_cnt - 1;
      end
      default: if (lempty && !m_mov) n_st = 0;
    endcase
    if (status_clear) begin m_tmo = 0; m_ovf = 0; end
    if (stall && (m_wait >= int'(drain_timeout))) m_tmo = 1;
    if (!m_mov) begin
      m_wait = 0;
      if (!active) m_timer = 0;
      else if (lfull || m_timer >= int'(flush_interval) || force_f) begin
        m_timer = 0;
        if (!lempty) m_mov = 1;
      end else m_timer++;
    end else begin
      if (lempty) begin m_mov = 0; m_timer = 0; m_wait = 0; end
      else if (cfull) begin if (m_wait < int'(drain_timeout)) m_wait++; end
      else m_wait = 0;
    end
    if (sreq) begin
      m_in = 1; m_idx = 0; m_keep = fits;
      if (!fits) begin m_ovf = 1; m_drops = (m_drops + 1) % (1 << DCW); end
    end else if (m_in && smp_valid) begin
      if (m_idx == NCH - 1) m_in = 0;
      m_idx++;
    end
    if (sreq) begin src_pend = NCH; src_ch = 0; src_scan++; end
    else if (smp_valid && src_pend > 0) begin src_pend--; src_ch++; end
    m_st = n_st; m_cnt = n_cnt; m_sp = n_sp;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else model_step();
  end

  // sample source: channel number in bits [3:0], scan number above
  always @(negedge clk) begin
    rd_ready <= ready_mode ? (cyc % 3 == 0) : ready_hold;
    if (src_pend > 0) begin
      smp_valid <= !gap_mode || cyc[0];
      smp_data  <= {src_scan[11:0], src_ch[3:0]};
    end else begin
      smp_valid <= noise;
      smp_data  <= 16'hFFFF;
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    chk(scan_req === pred_req(), "R1 scan_req", scan_req, pred_req());
    chk(rd_valid === (cq.size() > 0), "R5 R6 R10 rd_valid", rd_valid, cq.size() > 0);
    if (cq.size() > 0) chk(rd_data === cq[0], "R2 rd_data", rd_data, cq[0]);
    chk(busy === (m_st != 0), "R8 busy", busy, m_st != 0);
    chk(ovf_flag === m_ovf[0], "R3 R4 ovf_flag", ovf_flag, m_ovf);
    chk(drop_count === DCW'(m_drops), "R3 drop_count", drop_count, m_drops);
    chk(timeout_flag === m_tmo[0], "R7 timeout_flag", timeout_flag, m_tmo);
    if (rst_n && rd_valid && rd_ready) begin
      chk(rd_data[3:0] == 4'(exp_ch), "R2 channel order", rd_data[3:0], exp_ch);
      exp_ch = (exp_ch + 1) % NCH;
      words_read++;
    end
    if (rst_n && pred_req()) begin
      reqs++;
      if (gap_chk && last_req >= 0) chk(cyc - last_req == 40, "R1 period", cyc - last_req, 40);
      last_req = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask
  task automatic pulse_clear();
    @(negedge clk); status_clear = 1; @(negedge clk); status_clear = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
    #3;
    chk(busy === 1'b0, {tag, " reached idle"}, busy, 0);
    repeat (CDEPTH + 8) @(negedge clk);
    #3;
    chk(rd_valid === 1'b0, {tag, " consumer drained"}, rd_valid, 0);
    chk(words_read == NCH * (reqs - int'(drop_count)), {tag, " every kept word delivered"},
        words_read, NCH * (reqs - int'(drop_count)));
  endtask

  initial begin
    ready_hold = 1;
    repeat (3) @(negedge clk);
    #3;
    // R9 reset state
    chk(!busy && !rd_valid && !scan_req && !ovf_flag && !timeout_flag && drop_count == 0,
        "R9 reset outputs", {busy, rd_valid, scan_req, ovf_flag, timeout_flag}, 0);
    @(negedge clk); rst_n = 1;

    // steady acquisition, fast consumer, exact period
    gap_chk = 1;
    pulse_start();
    repeat (800) @(negedge clk);
    gap_chk = 0;
    pulse_stop();
    wait_idle("R8 phase A");
    chk(drop_count == 0, "R3 no drop with fast consumer", drop_count, 0);

    // stalled consumer: overflow and timeout
    scan_period = 20; ready_hold = 0;
    pulse_start();
    repeat (400) @(negedge clk);
    #3;
    chk(ovf_flag === 1'b1, "R3 overflow flagged", ovf_flag, 1);
    chk(drop_count > 0, "R3 scans dropped", drop_count, 1);
    chk(timeout_flag === 1'b1, "R7 timeout flagged", timeout_flag, 1);
    chk(rd_valid === 1'b1, "R6 consumer holds data", rd_valid, 1);
    ready_hold = 1;
    pulse_stop();
    pulse_clear();
    #3;
    chk(!ovf_flag && !timeout_flag, "R4 flags cleared", {ovf_flag, timeout_flag}, 0);
    wait_idle("R8 phase B");

    // slow gapped source, throttled consumer, noise between scans
    scan_period = 13; flush_interval = 50; drain_timeout = 8;
    gap_mode = 1; noise = 1; ready_mode = 1;
    pulse_start();
    repeat (700) @(negedge clk);
    pulse_start();
    #3;
    chk(busy === 1'b1, "R8 start while running ignored", busy, 1);
    repeat (700) @(negedge clk);
    pulse_stop();
    ready_mode = 0; ready_hold = 1;
    wait_idle("R8 phase C");
    chk(drop_count > 0, "R3 drops under slow consumer", drop_count, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule